// File: doc/BRIEF.md
# Register-Array LIFO Stack with Wrap-Detected Full and Empty Flags

This block is a last-in, first-out store held in a bank of registers. A pointer register of `PTR_W` bits (six by default, so 64 words) selects one slot. A push first advances the pointer and then writes the incoming word into the slot it now points at. A pop first reads the slot under the pointer and then moves the pointer back. The first word pushed therefore sits in slot 1, and the word that fills the stack sits in slot 0.

The block keeps no occupancy counter. It sets its full and empty flags by watching the pointer land on zero. When a push leaves the pointer at zero, the stack is full. When a pop leaves the pointer at zero, the stack is empty. The block drops any request that would corrupt the stack: a push while full, a pop while empty, or a push and a pop in the same cycle. For each such request it raises a one-cycle error pulse. Popped data comes out of a register and is marked valid on the cycle after the request.

Top module: `lifo_regstack`

## Requirements
- R1: After reset, `stk_ptr` is 0, `empty` is 1, `full` is 0, `err` is 0 and `pop_valid` is 0.
- R2: An accepted push is `push_req`=1 with `pop_req`=0 while `full`=0. It advances `stk_ptr` by one, modulo 2^PTR_W, and stores `push_data` in the slot at the new pointer value.
- R3: After an accepted push, `empty` is 0. `full` is 1 exactly when the new pointer value is 0, which happens on the 2^PTR_W-th push into an empty stack.
- R4: An accepted pop is `pop_req`=1 with `push_req`=0 while `empty`=0. On the following cycle `pop_data` holds the word stored in the slot at the old pointer and `pop_valid` is 1. `stk_ptr` decreases by one.
- R5: After an accepted pop, `full` is 0. `empty` is 1 exactly when the new pointer value is 0.
- R6: Words come out in the reverse of the order they went in, for a full fill and drain and for interleaved pushes and pops.
- R7: A push while `full`=1 is dropped. The pointer, the flags and the stored words are unchanged, and `err` is 1 on the next cycle.
- R8: A pop while `empty`=1 is dropped. The pointer and flags are unchanged, `pop_valid` stays 0, and `err` is 1 on the next cycle.
- R9: A push and a pop in the same cycle are both dropped. Nothing changes except that `err` is 1 on the next cycle.
- R10: `err` is high for one cycle per dropped request and is 0 after any cycle that carries no dropped request. `pop_valid` is 0 after any cycle without an accepted pop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| push_req | input | 1 | Request to push `push_data` |
| pop_req | input | 1 | Request to pop the top word |
| push_data | input | DATA_W | Word to push |
| pop_data | output | DATA_W | Registered popped word |
| pop_valid | output | 1 | `pop_data` holds a newly popped word |
| stk_ptr | output | PTR_W | Current stack pointer |
| full | output | 1 | Stack holds 2^PTR_W words |
| empty | output | 1 | Stack holds no words |
| err | output | 1 | One-cycle pulse for a dropped request |

## Verification
The stack is tried in three ways. The first fills all 64 slots with words computed from their push index and then drains them completely. This exercises every pointer value in both directions and shows that the full and empty flags follow the pointer's wrap to zero and are not set early or late. The second runs a short interleaved push/pop sequence, which separates true last-in ordering from simple slot replay. The third applies the three illegal request types at the full and empty boundaries and in mid-stack. Reading the pointer and the next pop after each one shows that the request really left the stack untouched, while the error pulse appears for exactly one cycle.

// File: rtl/stk_pkg.sv
package stk_pkg;
   typedef enum logic [1:0] {
      REQ_IDLE = 2'b00,
      REQ_PUSH = 2'b01,
      REQ_POP  = 2'b10,
      REQ_BAD  = 2'b11
   } stk_req_e;

   function automatic stk_req_e classify(input logic psh, input logic pop,
                                         input logic is_full, input logic is_empty);
      if (psh && pop)            return REQ_BAD;
      else if (psh && is_full)   return REQ_BAD;
      else if (pop && is_empty)  return REQ_BAD;
      else if (psh)              return REQ_PUSH;
      else if (pop)              return REQ_POP;
      else                       return REQ_IDLE;
   endfunction
endpackage

// File: rtl/stk_guard.sv
module stk_guard
   import stk_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic push_req,
   input  logic pop_req,
   input  logic full,
   input  logic empty,
   output logic do_push,
   output logic do_pop,
   output logic err
);
   stk_req_e kind;

   always_comb begin
      kind    = classify(push_req, pop_req, full, empty);
      do_push = (kind == REQ_PUSH);
      do_pop  = (kind == REQ_POP);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) err <= 1'b0;
      else        err <= (kind == REQ_BAD);
   end
endmodule

// File: rtl/stk_ptr.sv
module stk_ptr #(
   parameter int PTR_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             do_push,
   input  logic             do_pop,
   output logic [PTR_W-1:0] sp,
   output logic [PTR_W-1:0] sp_inc,
   output logic             full,
   output logic             empty
);
   logic [PTR_W-1:0] sp_dec;

   always_comb begin
      sp_inc = sp + 1'b1;
      sp_dec = sp - 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sp    <= '0;
         full  <= 1'b0;
         empty <= 1'b1;
      end else if (do_push) begin
         sp    <= sp_inc;
         full  <= (sp_inc == '0);
         empty <= 1'b0;
      end else if (do_pop) begin
         sp    <= sp_dec;
         empty <= (sp_dec == '0);
         full  <= 1'b0;
      end
   end
endmodule

// File: rtl/stk_store.sv
module stk_store #(
   parameter int DATA_W = 8,
   parameter int PTR_W  = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [PTR_W-1:0]  wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_en,
   input  logic [PTR_W-1:0]  rd_addr,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_valid
);
   localparam int DEPTH = 1 << PTR_W;

   logic [DEPTH-1:0][DATA_W-1:0] slot_q;

   for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk) begin
         if (wr_en && (wr_addr == PTR_W'(g))) q <= wr_data;
      end
      assign slot_q[g] = q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_data  <= '0;
         rd_valid <= 1'b0;
      end else begin
         rd_valid <= rd_en;
         if (rd_en) rd_data <= slot_q[rd_addr];
      end
   end
endmodule

// File: rtl/lifo_regstack.sv
module lifo_regstack #(
   parameter int DATA_W = 8,
   parameter int PTR_W  = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push_req,
   input  logic              pop_req,
   input  logic [DATA_W-1:0] push_data,
   output logic [DATA_W-1:0] pop_data,
   output logic              pop_valid,
   output logic [PTR_W-1:0]  stk_ptr,
   output logic              full,
   output logic              empty,
   output logic              err
);
   if (PTR_W < 2 || PTR_W > 10) begin : g_bad_ptr
      $error("lifo_regstack: PTR_W must lie in 2..10");
   end
   if (DATA_W < 1) begin : g_bad_data
      $error("lifo_regstack: DATA_W must be positive");
   end

   logic             do_push;
   logic             do_pop;
   logic [PTR_W-1:0] sp_inc;

   stk_guard u_guard (
      .clk      (clk),
      .rst_n    (rst_n),
      .push_req (push_req),
      .pop_req  (pop_req),
      .full     (full),
      .empty    (empty),
      .do_push  (do_push),
      .do_pop   (do_pop),
      .err      (err)
   );

   stk_ptr #(.PTR_W(PTR_W)) u_ptr (
      .clk     (clk),
      .rst_n   (rst_n),
      .do_push (do_push),
      .do_pop  (do_pop),
      .sp      (stk_ptr),
      .sp_inc  (sp_inc),
      .full    (full),
      .empty   (empty)
   );

   stk_store #(.DATA_W(DATA_W), .PTR_W(PTR_W)) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (do_push),
      .wr_addr  (sp_inc),
      .wr_data  (push_data),
      .rd_en    (do_pop),
      .rd_addr  (stk_ptr),
      .rd_data  (pop_data),
      .rd_valid (pop_valid)
   );
endmodule

// File: rtl/stk_checker.sv
module stk_checker #(
   parameter int DATA_W = 8,
   parameter int PTR_W  = 6
) (
   input logic              clk,
   input logic              rst_n,
   input logic              push_req,
   input logic              pop_req,
   input logic [DATA_W-1:0] pop_data,
   input logic              pop_valid,
   input logic [PTR_W-1:0]  stk_ptr,
   input logic              full,
   input logic              empty,
   input logic              err
);
   logic psh_ok, pop_ok, bad;
   assign psh_ok = push_req && !pop_req && !full;
   assign pop_ok = pop_req && !push_req && !empty;
   assign bad    = (push_req && pop_req) || (push_req && full) || (pop_req && empty);

   AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !(full && empty)); // R3
   AST_PUSH_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
      psh_ok |=> (stk_ptr == PTR_W'($past(stk_ptr) + 1'b1)) && !empty); // R2
   AST_FULL_ON_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      psh_ok |=> (full == (stk_ptr == '0))); // R3
   AST_POP_RETREAT: assert property (@(posedge clk) disable iff (!rst_n)
      pop_ok |=> (stk_ptr == PTR_W'($past(stk_ptr) - 1'b1)) && pop_valid); // R4
   AST_EMPTY_ON_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      pop_ok |=> (empty == (stk_ptr == '0)) && !full); // R5
   AST_BAD_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      bad |=> $stable(stk_ptr) && $stable(full) && $stable(empty) && err && !pop_valid); // R9
   AST_ERR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      !bad |=> !err); // R10
endmodule

bind lifo_regstack stk_checker #(.DATA_W(DATA_W), .PTR_W(PTR_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .push_req  (push_req),
   .pop_req   (pop_req),
   .pop_data  (pop_data),
   .pop_valid (pop_valid),
   .stk_ptr   (stk_ptr),
   .full      (full),
   .empty     (empty),
   .err       (err)
);

// File: tb/tb_lifo_regstack.sv
module tb_lifo_regstack;
   localparam int DW    = 8;
   localparam int PW    = 6;
   localparam int DEPTH = 1 << PW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          push_req = 1'b0;
   logic          pop_req = 1'b0;
   logic [DW-1:0] push_data = '0;
   logic [DW-1:0] pop_data;
   logic          pop_valid;
   logic [PW-1:0] stk_ptr;
   logic          full, empty, err;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #5 clk = ~clk;

   lifo_regstack #(.DATA_W(DW), .PTR_W(PW)) dut (
      .clk(clk), .rst_n(rst_n), .push_req(push_req), .pop_req(pop_req),
      .push_data(push_data), .pop_data(pop_data), .pop_valid(pop_valid),
      .stk_ptr(stk_ptr), .full(full), .empty(empty), .err(err)
   );

   function automatic logic [DW-1:0] word_of(input int i);
      return DW'(i * 37 + 5);
   endfunction

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic cyc(input logic p, input logic q, input logic [DW-1:0] d);
      push_req  = p;
      pop_req   = q;
      push_data = d;
      @(posedge clk);
      #2;
      push_req = 1'b0;
      pop_req  = 1'b0;
   endtask

   task automatic idle_check(input string req);
      cyc(1'b0, 1'b0, '0);
      chk(req, int'(err), 0);
      chk(req, int'(pop_valid), 0);
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #2;
      // R1 reset state
      chk("R1 ptr", int'(stk_ptr), 0);
      chk("R1 empty", int'(empty), 1);
      chk("R1 full", int'(full), 0);
      chk("R1 err", int'(err), 0);
      chk("R1 valid", int'(pop_valid), 0);
      rst_n = 1'b1;
      #10;

      // R8 pop on empty
      cyc(1'b0, 1'b1, '0);
      chk("R8 err", int'(err), 1);
      chk("R8 valid", int'(pop_valid), 0);
      chk("R8 ptr", int'(stk_ptr), 0);
      chk("R8 empty", int'(empty), 1);
      idle_check("R10 after R8");

      // R2 R3 full sweep of pushes
      for (int i = 1; i <= DEPTH; i++) begin
         cyc(1'b1, 1'b0, word_of(i));
         chk("R2 ptr", int'(stk_ptr), i % DEPTH);
         chk("R3 empty", int'(empty), 0);
         chk("R3 full", int'(full), (i == DEPTH) ? 1 : 0);
         chk("R2 err", int'(err), 0);
      end

      // R7 push on full
      cyc(1'b1, 1'b0, 8'hEE);
      chk("R7 err", int'(err), 1);
      chk("R7 ptr", int'(stk_ptr), 0);
      chk("R7 full", int'(full), 1);
      idle_check("R10 after R7");

      // R9 both while full
      cyc(1'b1, 1'b1, 8'hDD);
      chk("R9 err", int'(err), 1);
      chk("R9 valid", int'(pop_valid), 0);
      chk("R9 ptr", int'(stk_ptr), 0);
      chk("R9 full", int'(full), 1);

      // R4 R5 R6 drain, top word must be the 64th, untouched by R7/R9
      for (int i = DEPTH; i >= 1; i--) begin
         cyc(1'b0, 1'b1, '0);
         chk("R6 data", int'(pop_data), int'(word_of(i)));
         chk("R4 valid", int'(pop_valid), 1);
         chk("R4 ptr", int'(stk_ptr), i - 1);
         chk("R5 full", int'(full), 0);
         chk("R5 empty", int'(empty), (i == 1) ? 1 : 0);
      end
      idle_check("R10 after drain");

      // R6 interleaved, R9 mid-stack
      cyc(1'b1, 1'b0, 8'h11);
      cyc(1'b1, 1'b0, 8'h22);
      cyc(1'b1, 1'b1, 8'h99);
      chk("R9 mid err", int'(err), 1);
      chk("R9 mid ptr", int'(stk_ptr), 2);
      cyc(1'b0, 1'b1, '0);
      chk("R6 il1", int'(pop_data), 8'h22);
      cyc(1'b1, 1'b0, 8'h33);
      chk("R6 il ptr", int'(stk_ptr), 2);
      chk("R10 il err", int'(err), 0);
      cyc(1'b0, 1'b1, '0);
      chk("R6 il2", int'(pop_data), 8'h33);
      cyc(1'b0, 1'b1, '0);
      chk("R6 il3", int'(pop_data), 8'h11);
      chk("R5 il empty", int'(empty), 1);
      cyc(1'b0, 1'b1, '0);
      chk("R8 again err", int'(err), 1);
      chk("R8 again valid", int'(pop_valid), 0);

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule